// File: doc/BRIEF.md
# Multiprocessor Interrupt Routing Register Block

This block holds the control and status registers that steer device interrupts and inter-processor interrupts to a small set of CPUs. It has a single register port. Each access carries:

- a request strobe and a write flag;
- a size code and a byte offset from the block base;
- 64-bit write data;
- the number of the CPU that issued the access.

Only 64-bit accesses are accepted. A one-cycle error flag marks any other size, and such an access changes nothing.

Device interrupts arrive as a vector of level inputs. That vector is captured every cycle into a shared raw register. Each CPU owns a mask register. It also owns a request register, which always holds that CPU's mask ANDed with the raw vector. A CPU's device interrupt line is driven from a per-bit posted vector:

- A mask write posts bits that become both enabled and requesting.
- A mask write withdraws bits that stop requesting.
- A change of the raw inputs re-derives every CPU's posted bits.

A single control register sets and clears the inter-processor interrupt pending bits and clears the interval-timer pending bits. Timer ticks set timer pending bits from outside the block.

Read data appears on the cycle after the read request and holds until the next read.

Top module: `irq_route_csr`

## Requirements
- R1: After reset all registers are zero: no device line or inter-processor line is high, the error flag is low and read data is zero.
- R2: An access whose size code is not 2'b11 (64-bit) raises the error flag in the cycle after the request, changes no register, and a read of that kind returns zero.
- R3: The register index is offset bits [13:6]. Indices 8..11 hold the mask of CPU 0..3 (read/write). Indices 12..15 hold the request register of CPU 0..3, which is read-only: writes to it are ignored.
- R4: After every clock edge each CPU's request register equals its mask ANDed with the raw register. Index 16 reads the raw register, which captures the device inputs on every edge.
- R5: A CPU's device line is high exactly when it has a posted bit. A mask write posts the changed bits that are set in both the new mask and the new request, and withdraws the changed bits that were requesting before and are not now. A change of the device inputs re-derives all posted bits from the new requests.
- R6: Offset bit 15 selects a bulk mask window and offset bit 14 (with bit 15 clear) a bulk request window. In both, the CPU number is offset bits [9:4]. A CPU number of NCPU or above reads zero and its writes are ignored.
- R7: A write to the control register at index 20 clears the inter-processor pending bits named in data bits [11:8] and then sets those named in bits [15:12], so a set wins over a clear of the same bit. Each inter-processor output follows its pending bit.
- R8: In the same control register write, data bits [7:4] clear timer pending bits. A timer tick input sets its pending bit, and a tick wins over a clear in the same cycle.
- R9: A read of index 20 returns the inter-processor pending bits in [11:8], the timer pending bits in [7:4], the requesting CPU number in [1:0], and zero elsewhere.
- R10: Index 24 reads the inter-processor pending bits in [3:0] and index 25 the timer pending bits in [3:0]. Index 0, indices 1..4 and every unmapped index read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| csr_req | input | 1 | Access request, one cycle per access |
| csr_wr | input | 1 | 1 = write, 0 = read |
| csr_size | input | 2 | Size code, 2'b11 = 64-bit |
| csr_addr | input | ADDR_W | Byte offset from the block base |
| csr_wdata | input | 64 | Write data |
| csr_cpu | input | CPU_IDW | Number of the requesting CPU |
| csr_rdata | output | 64 | Read data, valid the cycle after a read |
| csr_err | output | 1 | One-cycle flag for an illegal access size |
| dev_irq_i | input | RAW_W | Device interrupt levels |
| tmr_tick_i | input | NCPU | Interval-timer tick per CPU |
| dev_int_o | output | NCPU | Device interrupt line per CPU |
| ipi_o | output | NCPU | Inter-processor interrupt line per CPU |

## Verification
The hardest case to reach is a mask write that changes only some bits while others stay enabled. In that case a posted bit must be withdrawn without touching bits whose mask did not change, and the bench can only see this through the per-CPU line. The stimulus gets there in steps:

1. It sets the raw inputs first.
2. It enables a mask covering several requesting bits.
3. It raises a second raw bit that only another CPU's mask covers.
4. It rewrites the first mask so that every posted bit drops while unrelated enabled bits remain, and checks that the line falls.

Bulk-window aliasing is exposed by writing CPU slot 5 and then reading back the mask of slot 1, which a truncated CPU number would overwrite.

// File: rtl/irq_csr_pkg.sv
package irq_csr_pkg;

  // Offset layout: register index in [13:6], bulk windows on the top bits.
  localparam int unsigned IDX_LSB = 6;
  localparam int unsigned IDX_W   = 8;
  localparam int unsigned BULK_CPU_LSB = 4;
  localparam int unsigned BULK_CPU_W   = 6;

  localparam logic [IDX_W-1:0] IDX_CTL     = 8'd0;
  localparam logic [IDX_W-1:0] IDX_ARR_LO  = 8'd1;
  localparam logic [IDX_W-1:0] IDX_ARR_HI  = 8'd4;
  localparam logic [IDX_W-1:0] IDX_MASK_LO = 8'd8;
  localparam logic [IDX_W-1:0] IDX_MASK_HI = 8'd11;
  localparam logic [IDX_W-1:0] IDX_REQ_LO  = 8'd12;
  localparam logic [IDX_W-1:0] IDX_REQ_HI  = 8'd15;
  localparam logic [IDX_W-1:0] IDX_RAW     = 8'd16;
  localparam logic [IDX_W-1:0] IDX_MISC    = 8'd20;
  localparam logic [IDX_W-1:0] IDX_IPI     = 8'd24;
  localparam logic [IDX_W-1:0] IDX_TMR     = 8'd25;

  localparam logic [1:0] SZ_DWORD = 2'b11;

  // Control register field positions (write and read views).
  localparam int unsigned MISC_IPI_SET_LSB = 12;
  localparam int unsigned MISC_IPI_CLR_LSB = 8;
  localparam int unsigned MISC_TMR_CLR_LSB = 4;
  localparam int unsigned MISC_IPI_RD_LSB  = 8;
  localparam int unsigned MISC_TMR_RD_LSB  = 4;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ZERO,
    SEL_MASK,
    SEL_REQ,
    SEL_RAW,
    SEL_MISC,
    SEL_IPI,
    SEL_TMR
  } sel_e;

  typedef struct packed {
    sel_e                  sel;
    logic [BULK_CPU_W-1:0] cpu;
    logic                  cpu_ok;
  } dec_t;

endpackage

// File: rtl/irq_csr_decode.sv
module irq_csr_decode
  import irq_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned NCPU   = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);

  localparam int unsigned BULK_MASK_BIT = ADDR_W - 1;
  localparam int unsigned BULK_REQ_BIT  = ADDR_W - 2;
  localparam logic [BULK_CPU_W-1:0] NCPU_LIM = BULK_CPU_W'(NCPU);

  logic [IDX_W-1:0]      idx;
  logic [BULK_CPU_W-1:0] bulk_cpu;

  assign idx      = addr[IDX_LSB +: IDX_W];
  assign bulk_cpu = addr[BULK_CPU_LSB +: BULK_CPU_W];

  always_comb begin
    dec.sel = SEL_NONE;
    dec.cpu = '0;
    if (addr[BULK_MASK_BIT]) begin
      dec.sel = SEL_MASK;
      dec.cpu = bulk_cpu;
    end else if (addr[BULK_REQ_BIT]) begin
      dec.sel = SEL_REQ;
      dec.cpu = bulk_cpu;
    end else begin
      case (idx) inside
        IDX_CTL:                  dec.sel = SEL_ZERO;
        [IDX_ARR_LO:IDX_ARR_HI]:  dec.sel = SEL_ZERO;
        [IDX_MASK_LO:IDX_MASK_HI]: begin
          dec.sel = SEL_MASK;
          dec.cpu = BULK_CPU_W'(idx[1:0]);
        end
        [IDX_REQ_LO:IDX_REQ_HI]: begin
          dec.sel = SEL_REQ;
          dec.cpu = BULK_CPU_W'(idx[1:0]);
        end
        IDX_RAW:  dec.sel = SEL_RAW;
        IDX_MISC: dec.sel = SEL_MISC;
        IDX_IPI:  dec.sel = SEL_IPI;
        IDX_TMR:  dec.sel = SEL_TMR;
        default:  dec.sel = SEL_NONE;
      endcase
    end
    dec.cpu_ok = (dec.cpu < NCPU_LIM);
  end

endmodule

// File: rtl/irq_cpu_slice.sv
module irq_cpu_slice #(
  parameter int unsigned RAW_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mask_we,
  input  logic [RAW_W-1:0] mask_wdata,
  input  logic [RAW_W-1:0] raw_in,
  input  logic             raw_chg,
  output logic [RAW_W-1:0] mask_o,
  output logic [RAW_W-1:0] req_o,
  output logic             line_o
);

  logic [RAW_W-1:0] mask_q, mask_nxt;
  logic [RAW_W-1:0] req_q, req_nxt;
  logic [RAW_W-1:0] post_q, post_nxt;
  logic [RAW_W-1:0] flip, post_set, post_clr;
  logic             upd_en;

  // Next state: request follows new mask and newly captured raw levels.
  always_comb begin
    mask_nxt = mask_we ? mask_wdata : mask_q;
    req_nxt  = mask_nxt & raw_in;
    flip     = mask_q ^ mask_nxt;
    post_set = flip & mask_nxt & req_nxt;
    post_clr = flip & req_q & ~req_nxt;
    if (raw_chg) post_nxt = req_nxt;
    else         post_nxt = (post_q & ~post_clr) | post_set;
    upd_en   = mask_we | raw_chg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      req_q  <= '0;
      post_q <= '0;
    end else begin
      if (mask_we) mask_q <= mask_nxt;
      if (upd_en) begin
        req_q  <= req_nxt;
        post_q <= post_nxt;
      end
    end
  end

  assign mask_o = mask_q;
  assign req_o  = req_q;
  assign line_o = |post_q;

  // R5: the edge-driven posted bits never drift from the request value.
  a_r5_post_tracks_req: assert property (@(posedge clk) disable iff (!rst_n)
    post_q == req_q);

  // R5: a line only rises after a mask write or a raw change.
  a_r5_line_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_o) |-> $past(mask_we || raw_chg));

endmodule

// File: rtl/irq_pend_vec.sv
module irq_pend_vec #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q, q_nxt;
  logic         en;

  // Clear applied first, set second: a set of the same bit wins.
  always_comb begin
    q_nxt = (q & ~clr_i) | set_i;
    en    = (|set_i) | (|clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= q_nxt;
  end

  assign q_o = q;

  // R7 (and R8 for the timer copy): requested bits land.
  a_r7_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_i) |=> ((q_o & $past(set_i)) == $past(set_i)));

  // R7 (and R8): cleared bits without a competing set drop.
  a_r7_clr_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_i & ~set_i)) |=> ((q_o & $past(clr_i & ~set_i)) == '0));

endmodule

// File: rtl/irq_route_csr.sv
module irq_route_csr
  import irq_csr_pkg::*;
#(
  parameter int unsigned NCPU   = 4,
  parameter int unsigned RAW_W  = 64,
  parameter int unsigned ADDR_W = 16,
  localparam int unsigned CPU_IDW = (NCPU > 1) ? $clog2(NCPU) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               csr_req,
  input  logic               csr_wr,
  input  logic [1:0]         csr_size,
  input  logic [ADDR_W-1:0]  csr_addr,
  input  logic [63:0]        csr_wdata,
  input  logic [CPU_IDW-1:0] csr_cpu,
  output logic [63:0]        csr_rdata,
  output logic               csr_err,
  input  logic [RAW_W-1:0]   dev_irq_i,
  input  logic [NCPU-1:0]    tmr_tick_i,
  output logic [NCPU-1:0]    dev_int_o,
  output logic [NCPU-1:0]    ipi_o
);

  localparam int unsigned DATA_W = 64;

  dec_t dec;

  logic acc_ok, acc_bad, wr_ok, rd_en;
  logic mask_wr, misc_wr;
  logic [RAW_W-1:0] raw_q;
  logic             raw_chg;
  logic [NCPU-1:0][RAW_W-1:0] mask_arr, req_arr;
  logic [NCPU-1:0] ipi_q, tmr_q;
  logic [NCPU-1:0] ipi_set, ipi_clr, tmr_clr;
  logic [DATA_W-1:0] rd_mux, rdata_q, rdata_nxt;
  logic              err_q;

  irq_csr_decode #(.ADDR_W(ADDR_W), .NCPU(NCPU)) u_dec (
    .addr (csr_addr),
    .dec  (dec)
  );

  // Access qualification.
  always_comb begin
    acc_ok  = csr_req && (csr_size == SZ_DWORD);
    acc_bad = csr_req && (csr_size != SZ_DWORD);
    wr_ok   = acc_ok && csr_wr;
    rd_en   = csr_req && !csr_wr;
    mask_wr = wr_ok && (dec.sel == SEL_MASK);
    misc_wr = wr_ok && (dec.sel == SEL_MISC);
    raw_chg = (dev_irq_i != raw_q);
  end

  // Shared raw register, captured every edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= dev_irq_i;
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic we_c;
    assign we_c = mask_wr && dec.cpu_ok && (dec.cpu == BULK_CPU_W'(c));

    irq_cpu_slice #(.RAW_W(RAW_W)) u_slice (
      .clk        (clk),
      .rst_n      (rst_n),
      .mask_we    (we_c),
      .mask_wdata (csr_wdata[RAW_W-1:0]),
      .raw_in     (dev_irq_i),
      .raw_chg    (raw_chg),
      .mask_o     (mask_arr[c]),
      .req_o      (req_arr[c]),
      .line_o     (dev_int_o[c])
    );

    // R4: request register equals mask AND raw after each edge.
    a_r4_req_is_masked_raw: assert property (@(posedge clk) disable iff (!rst_n)
      req_arr[c] == (mask_arr[c] & raw_q));
  end

  // Pending vectors controlled through the control register.
  always_comb begin
    ipi_set = misc_wr ? csr_wdata[MISC_IPI_SET_LSB +: NCPU] : '0;
    ipi_clr = misc_wr ? csr_wdata[MISC_IPI_CLR_LSB +: NCPU] : '0;
    tmr_clr = misc_wr ? csr_wdata[MISC_TMR_CLR_LSB +: NCPU] : '0;
  end

  irq_pend_vec #(.W(NCPU)) u_ipi (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (ipi_set),
    .clr_i (ipi_clr),
    .q_o   (ipi_q)
  );

  irq_pend_vec #(.W(NCPU)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (tmr_tick_i),
    .clr_i (tmr_clr),
    .q_o   (tmr_q)
  );

  // Read selection.
  always_comb begin
    rd_mux = '0;
    case (dec.sel)
      SEL_MASK: begin
        for (int c = 0; c < NCPU; c++)
          if (dec.cpu_ok && (dec.cpu == BULK_CPU_W'(c)))
            rd_mux[RAW_W-1:0] = mask_arr[c];
      end
      SEL_REQ: begin
        for (int c = 0; c < NCPU; c++)
          if (dec.cpu_ok && (dec.cpu == BULK_CPU_W'(c)))
            rd_mux[RAW_W-1:0] = req_arr[c];
      end
      SEL_RAW:  rd_mux[RAW_W-1:0] = raw_q;
      SEL_MISC: begin
        rd_mux[MISC_IPI_RD_LSB +: NCPU] = ipi_q;
        rd_mux[MISC_TMR_RD_LSB +: NCPU] = tmr_q;
        rd_mux[CPU_IDW-1:0]             = csr_cpu;
      end
      SEL_IPI:  rd_mux[NCPU-1:0] = ipi_q;
      SEL_TMR:  rd_mux[NCPU-1:0] = tmr_q;
      default:  rd_mux = '0;
    endcase
    rdata_nxt = acc_ok ? rd_mux : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (rd_en) rdata_q <= rdata_nxt;
      err_q <= acc_bad;
    end
  end

  assign csr_rdata = rdata_q;
  assign csr_err   = err_q;
  assign ipi_o     = ipi_q;

  // R2: the error flag only follows a request.
  a_r2_err_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    csr_err |-> $past(csr_req));

  // R2: an illegal-size write leaves the pending bits alone.
  a_r2_bad_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_req && csr_wr && (csr_size != SZ_DWORD)) |=> $stable(ipi_o));

  // R6: bulk mask write to a CPU slot beyond NCPU changes no mask.
  a_r6_oor_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_req && csr_wr && (csr_size == SZ_DWORD) && csr_addr[ADDR_W-1]
     && (csr_addr[BULK_CPU_LSB +: BULK_CPU_W] >= BULK_CPU_W'(NCPU)))
    |=> $stable(mask_arr));

endmodule

// File: tb/tb_irq_route_csr.sv
`timescale 1ns/1ps
module tb_irq_route_csr;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        csr_req, csr_wr;
  logic [1:0]  csr_size;
  logic [15:0] csr_addr;
  logic [63:0] csr_wdata;
  logic [1:0]  csr_cpu;
  logic [63:0] csr_rdata;
  logic        csr_err;
  logic [63:0] dev_irq_i;
  logic [3:0]  tmr_tick_i;
  logic [3:0]  dev_int_o, ipi_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_route_csr dut (
    .clk(clk), .rst_n(rst_n), .csr_req(csr_req), .csr_wr(csr_wr),
    .csr_size(csr_size), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .csr_cpu(csr_cpu), .csr_rdata(csr_rdata), .csr_err(csr_err),
    .dev_irq_i(dev_irq_i), .tmr_tick_i(tmr_tick_i),
    .dev_int_o(dev_int_o), .ipi_o(ipi_o)
  );

  typedef struct packed {
    logic [1:0]  op;    // 0 idle, 1 read, 2 write
    logic [1:0]  sz;
    logic [15:0] addr;
    logic [15:0] wd;
    logic [1:0]  cpu;
    logic [15:0] din;
    logic        rchk;
    logic [15:0] rexp;
    logic        err;
    logic [3:0]  dev;
    logic [3:0]  ipi;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 2'd3, 16'h0000, 16'h0000, 2'd0, 16'h0000, 1'b0, 16'h0000, 1'b0, 4'h0, 4'h0, 4'd1},  // R1 idle
    '{2'd2, 2'd3, 16'h0200, 16'h000F, 2'd0, 16'h0005, 1'b0, 16'h0000, 1'b0, 4'h1, 4'h0, 4'd5},  // R5 post
    '{2'd1, 2'd3, 16'h0300, 16'h0000, 2'd0, 16'h0005, 1'b1, 16'h0005, 1'b0, 4'h1, 4'h0, 4'd4},  // R4 req0
    '{2'd2, 2'd3, 16'h0240, 16'h0030, 2'd0, 16'h0005, 1'b0, 16'h0000, 1'b0, 4'h1, 4'h0, 4'd5},  // R5 no req
    '{2'd0, 2'd3, 16'h0000, 16'h0000, 2'd0, 16'h0015, 1'b0, 16'h0000, 1'b0, 4'h3, 4'h0, 4'd4},  // R4 raw chg
    '{2'd1, 2'd3, 16'h0400, 16'h0000, 2'd0, 16'h0015, 1'b1, 16'h0015, 1'b0, 4'h3, 4'h0, 4'd4},  // R4 raw rd
    '{2'd2, 2'd3, 16'h0200, 16'h000A, 2'd0, 16'h0015, 1'b0, 16'h0000, 1'b0, 4'h2, 4'h0, 4'd5},  // R5 withdraw
    '{2'd2, 2'd3, 16'h0300, 16'h00FF, 2'd0, 16'h0015, 1'b0, 16'h0000, 1'b0, 4'h2, 4'h0, 4'd3},  // R3 req ro
    '{2'd1, 2'd3, 16'h0300, 16'h0000, 2'd0, 16'h0015, 1'b1, 16'h0000, 1'b0, 4'h2, 4'h0, 4'd3},  // R3
    '{2'd2, 2'd3, 16'h8020, 16'h0004, 2'd0, 16'h0015, 1'b0, 16'h0000, 1'b0, 4'h6, 4'h0, 4'd6},  // R6 bulk wr
    '{2'd1, 2'd3, 16'h4020, 16'h0000, 2'd0, 16'h0015, 1'b1, 16'h0004, 1'b0, 4'h6, 4'h0, 4'd6},  // R6 bulk req
    '{2'd1, 2'd3, 16'h8020, 16'h0000, 2'd0, 16'h0015, 1'b1, 16'h0004, 1'b0, 4'h6, 4'h0, 4'd6},  // R6 bulk mask
    '{2'd1, 2'd3, 16'h8050, 16'h0000, 2'd0, 16'h0015, 1'b1, 16'h0000, 1'b0, 4'h6, 4'h0, 4'd6},  // R6 oor rd
    '{2'd2, 2'd3, 16'h8050, 16'h00FF, 2'd0, 16'h0015, 1'b0, 16'h0000, 1'b0, 4'h6, 4'h0, 4'd6},  // R6 oor wr
    '{2'd2, 2'd3, 16'h0500, 16'h5000, 2'd0, 16'h0015, 1'b0, 16'h0000, 1'b0, 4'h6, 4'h5, 4'd7},  // R7 set
    '{2'd2, 2'd3, 16'h0500, 16'h3100, 2'd0, 16'h0015, 1'b0, 16'h0000, 1'b0, 4'h6, 4'h7, 4'd7},  // R7 clr+set
    '{2'd2, 2'd3, 16'h0500, 16'h0400, 2'd0, 16'h0015, 1'b0, 16'h0000, 1'b0, 4'h6, 4'h3, 4'd7},  // R7 clr
    '{2'd1, 2'd3, 16'h0600, 16'h0000, 2'd0, 16'h0015, 1'b1, 16'h0003, 1'b0, 4'h6, 4'h3, 4'd10}, // R10 ipi rd
    '{2'd1, 2'd3, 16'h0500, 16'h0000, 2'd2, 16'h0015, 1'b1, 16'h0302, 1'b0, 4'h6, 4'h3, 4'd9},  // R9 misc rd
    '{2'd2, 2'd2, 16'h0500, 16'hF000, 2'd0, 16'h0015, 1'b0, 16'h0000, 1'b1, 4'h6, 4'h3, 4'd2},  // R2 bad wr
    '{2'd1, 2'd0, 16'h8020, 16'h0000, 2'd0, 16'h0015, 1'b1, 16'h0000, 1'b1, 4'h6, 4'h3, 4'd2},  // R2 bad rd
    '{2'd1, 2'd3, 16'h0200, 16'h0000, 2'd0, 16'h0015, 1'b1, 16'h000A, 1'b0, 4'h6, 4'h3, 4'd3},  // R3 mask0
    '{2'd1, 2'd3, 16'h0000, 16'h0000, 2'd0, 16'h0015, 1'b1, 16'h0000, 1'b0, 4'h6, 4'h3, 4'd10}, // R10 ctl
    '{2'd1, 2'd3, 16'h0240, 16'h0000, 2'd0, 16'h0015, 1'b1, 16'h0030, 1'b0, 4'h6, 4'h3, 4'd6},  // R6 no alias
    '{2'd1, 2'd3, 16'h0080, 16'h0000, 2'd0, 16'h0015, 1'b1, 16'h0000, 1'b0, 4'h6, 4'h3, 4'd10}, // R10 arr
    '{2'd2, 2'd3, 16'h02C0, 16'h0010, 2'd0, 16'h0015, 1'b0, 16'h0000, 1'b0, 4'hE, 4'h3, 4'd5},  // R5 cpu3
    '{2'd0, 2'd3, 16'h0000, 16'h0000, 2'd0, 16'h0005, 1'b0, 16'h0000, 1'b0, 4'h4, 4'h3, 4'd4},  // R4 raw drop
    '{2'd1, 2'd3, 16'h03C0, 16'h0000, 2'd0, 16'h0005, 1'b1, 16'h0000, 1'b0, 4'h4, 4'h3, 4'd4}   // R4 req3
  };

  task automatic chk(input bit ok, input string rq, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // Called at a negative edge; returns at the next negative edge.
  task automatic step(input logic [1:0] op, input logic [1:0] sz,
                      input logic [15:0] addr, input logic [15:0] wd,
                      input logic [1:0] cpu);
    csr_req   = (op != 2'd0);
    csr_wr    = (op == 2'd2);
    csr_size  = sz;
    csr_addr  = addr;
    csr_wdata = {48'h0, wd};
    csr_cpu   = cpu;
    @(posedge clk);
    @(negedge clk);
    csr_req    = 1'b0;
    csr_wr     = 1'b0;
    tmr_tick_i = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; csr_req = 1'b0; csr_wr = 1'b0; csr_size = 2'b11;
    csr_addr = '0; csr_wdata = '0; csr_cpu = '0; dev_irq_i = '0; tmr_tick_i = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(dev_int_o == 4'h0, "R1 dev", 64'(dev_int_o), 64'h0);
    chk(ipi_o == 4'h0, "R1 ipi", 64'(ipi_o), 64'h0);
    chk(csr_err == 1'b0, "R1 err", 64'(csr_err), 64'h0);
    chk(csr_rdata == 64'h0, "R1 rdata", csr_rdata, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      dev_irq_i = {48'h0, VEC[i].din};
      step(VEC[i].op, VEC[i].sz, VEC[i].addr, VEC[i].wd, VEC[i].cpu);
      chk(csr_err == VEC[i].err, $sformatf("R%0d err v%0d", VEC[i].rq, i),
          64'(csr_err), 64'(VEC[i].err));
      chk(dev_int_o == VEC[i].dev, $sformatf("R%0d dev v%0d", VEC[i].rq, i),
          64'(dev_int_o), 64'(VEC[i].dev));
      chk(ipi_o == VEC[i].ipi, $sformatf("R%0d ipi v%0d", VEC[i].rq, i),
          64'(ipi_o), 64'(VEC[i].ipi));
      if (VEC[i].rchk)
        chk(csr_rdata == {48'h0, VEC[i].rexp},
            $sformatf("R%0d rdata v%0d", VEC[i].rq, i),
            csr_rdata, {48'h0, VEC[i].rexp});
    end

    // R8: timer ticks set pending bits of CPU 1 and 3
    tmr_tick_i = 4'b1010;
    step(2'd0, 2'd3, 16'h0000, 16'h0000, 2'd0);
    step(2'd1, 2'd3, 16'h0640, 16'h0000, 2'd0);
    chk(csr_rdata == 64'hA, "R8 tick set", csr_rdata, 64'hA);
    // R9: control read from CPU 3 with both pending vectors populated
    step(2'd1, 2'd3, 16'h0500, 16'h0000, 2'd3);
    chk(csr_rdata == 64'h3A3, "R9 misc layout", csr_rdata, 64'h3A3);
    // R8: clear CPU 1 timer bit
    step(2'd2, 2'd3, 16'h0500, 16'h0020, 2'd0);
    step(2'd1, 2'd3, 16'h0640, 16'h0000, 2'd0);
    chk(csr_rdata == 64'h8, "R8 clear", csr_rdata, 64'h8);
    // R8: tick wins over clear in the same cycle
    tmr_tick_i = 4'b1000;
    step(2'd2, 2'd3, 16'h0500, 16'h0080, 2'd0);
    step(2'd1, 2'd3, 16'h0640, 16'h0000, 2'd0);
    chk(csr_rdata == 64'h8, "R8 tick wins", csr_rdata, 64'h8);
    step(2'd2, 2'd3, 16'h0500, 16'h0080, 2'd0);
    step(2'd1, 2'd3, 16'h0640, 16'h0000, 2'd0);
    chk(csr_rdata == 64'h0, "R8 clear last", csr_rdata, 64'h0);
    chk(ipi_o == 4'h3, "R7 timer clear leaves ipi", 64'(ipi_o), 64'h3);

    // R1: reset in the middle of activity
    rst_n = 1'b0;
    @(negedge clk);
    chk(dev_int_o == 4'h0, "R1 mid dev", 64'(dev_int_o), 64'h0);
    chk(ipi_o == 4'h0, "R1 mid ipi", 64'(ipi_o), 64'h0);
    chk(csr_rdata == 64'h0, "R1 mid rdata", csr_rdata, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    step(2'd1, 2'd3, 16'h0200, 16'h0000, 2'd0);
    chk(csr_rdata == 64'h0, "R1 mask0 cleared", csr_rdata, 64'h0);
    chk(dev_int_o == 4'h0, "R1 no line with zero mask", 64'(dev_int_o), 64'h0);

    finish_run();
  end

endmodule